// File: doc/BRIEF.md
# RTC register snapshot controller

This block sits between a set of free-running BCD timekeeping counters and a byte-wide register window that a host reads and writes like plain memory. A fractional-second tick input is divided down to one-second events. On each event the live counters advance through seconds, minutes, hours, day of week, date, month and year. One cycle later every field is copied into host-visible mirror registers in a single step. The mirrors are separate storage cells from the counters. A host read therefore never sees a counter in the middle of a carry.

A control byte gives the host two ways to freeze the mirrors. A read freeze holds a consistent snapshot while the host reads it. A write freeze lets the host load new time values. Releasing the write freeze copies those values into the counters and restarts the sub-second phase. Bit 7 of the seconds register stops and restarts timekeeping. The control byte also carries a six-bit calibration setting for a downstream divider. Addresses below the register window reach a small RAM through the same port.

Top module: `rtc_snapshot_ctrl`

## Requirements
- R1: The eight registers occupy the highest eight addresses of the window. Offset 0 is control. Offsets 1 to 7 are seconds, minutes, hours, day of week, date, month and year. Every lower address reaches RAM. `bus_rdata` shows the location addressed one cycle earlier.
- R2: The counters hold packed BCD in 24-hour form. Seconds and minutes wrap at 59, hours at 23, and day of week runs 1 to 7. The date wraps at 28, 29, 30 or 31 according to the month. February has 29 days when the year value is divisible by 4, and the year wraps from 99 to 00.
- R3: A second elapses after SUBDIV pulses of `phase_tick`. In the following cycle, all seven mirror fields take the counter values together.
- R4: While control bit 6 (read freeze) is 1, refreshes stop and the mirrors keep the last captured time.
- R5: A refresh already started by a second event completes even when a freeze bit is written in that same copy cycle.
- R6: After both freeze bits are cleared, the mirrors resume refreshing at the next second event, at most one second later.
- R7: While control bit 7 (write freeze) is 1, refreshes stop and host writes to the time registers persist.
- R8: Writing control bit 7 from 1 to 0 loads all seven mirror fields into the counters and restarts the sub-second phase. The next second event then comes exactly SUBDIV ticks later.
- R9: Bit 7 of the seconds register is an oscillator stop bit, and it is 1 after reset. While it is 1 the counters do not advance. After it is cleared, the first second event comes SUBDIV ticks later.
- R10: Control bits 5 to 0 (bit 5 sign, bits 4 to 0 magnitude) read back as written and drive `cal_setting`.
- R11: The write freeze dominates. With both freeze bits set, clearing only bit 6 does not resume refreshing and does not load the counters.
- R12: A byte written to a RAM address reads back unchanged.
- R13: After reset the registers read as follows: control 00, seconds 80, minutes 00, hours 00, day 01, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_tick | input | 1 | Fractional-second tick, SUBDIV pulses per second |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the address |
| cal_setting | output | 6 | Calibration sign and magnitude from control bits 5:0 |
| osc_running | output | 1 | High while the stop bit is clear |

## Verification
The collision that matters is a host write that sets the read freeze in the same cycle as the mirror copy that follows a second event. The bench reaches this by counting phase ticks from a known phase. It then issues the control write at the clock edge that performs the copy. The result passes only if the mirrors hold the newly advanced second. Later seconds must then stay frozen until the bit is cleared.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [6:0] secs;
    } rtc_time_t;

    typedef logic [7:1][7:0] time_bytes_t;

    localparam int unsigned REG_COUNT = 8;
    localparam int unsigned OFS_W     = $clog2(REG_COUNT);

    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [OFS_W-1:0] OFS_SEC  = 3'd1;

    localparam int CTRL_WFRZ = 7;
    localparam int CTRL_RFRZ = 6;

    localparam rtc_time_t TIME_AT_RESET = '{
        year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
        hours: 8'h00, mins: 8'h00, secs: 7'h00
    };

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = v + 8'd1;
        return r;
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic [4:0] m;
        m = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (m[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        logic [7:0] r;
        case (mo)
            8'h02:                     r = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                   r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic time_bytes_t to_bytes(input rtc_time_t t);
        time_bytes_t b;
        b[1] = {1'b0, t.secs};
        b[2] = t.mins;
        b[3] = t.hours;
        b[4] = t.dow;
        b[5] = t.date;
        b[6] = t.month;
        b[7] = t.year;
        return b;
    endfunction

    function automatic rtc_time_t from_bytes(input time_bytes_t b);
        rtc_time_t t;
        t.secs  = b[1][6:0];
        t.mins  = b[2];
        t.hours = b[3];
        t.dow   = b[4];
        t.date  = b[5];
        t.month = b[6];
        t.year  = b[7];
        return t;
    endfunction

endpackage

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
    import rtc_snap_pkg::*;
#(
    parameter int unsigned SUBDIV = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      phase_tick,
    input  logic      osc_stop,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t live,
    output logic      sec_evt
);
    localparam int unsigned PH_W = (SUBDIV > 2) ? $clog2(SUBDIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUBDIV - 1);

    logic [PH_W-1:0] phase_q;
    rtc_time_t       live_q;
    rtc_time_t       nxt;

    assign sec_evt = phase_tick && !osc_stop && !load && (phase_q == PH_LAST);
    assign live    = live_q;

    always_ff @(posedge clk) begin
        if (rst || load || osc_stop) phase_q <= '0;
        else if (phase_tick)         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    always_comb begin
        nxt = live_q;
        if (live_q.secs == 7'h59) begin
            nxt.secs = '0;
            if (live_q.mins == 8'h59) begin
                nxt.mins = '0;
                if (live_q.hours == 8'h23) begin
                    nxt.hours = '0;
                    nxt.dow   = (live_q.dow == 8'h07) ? 8'h01 : bcd_inc8(live_q.dow);
                    if (live_q.date == month_last(live_q.month, live_q.year)) begin
                        nxt.date = 8'h01;
                        if (live_q.month == 8'h12) begin
                            nxt.month = 8'h01;
                            nxt.year  = (live_q.year == 8'h99) ? 8'h00 : bcd_inc8(live_q.year);
                        end else begin
                            nxt.month = bcd_inc8(live_q.month);
                        end
                    end else begin
                        nxt.date = bcd_inc8(live_q.date);
                    end
                end else begin
                    nxt.hours = bcd_inc8(live_q.hours);
                end
            end else begin
                nxt.mins = bcd_inc8(live_q.mins);
            end
        end else begin
            nxt.secs = 7'(bcd_inc8({1'b0, live_q.secs}));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          live_q <= TIME_AT_RESET;
        else if (load)    live_q <= load_val;
        else if (sec_evt) live_q <= nxt;
    end

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && !load) |=> $stable(live_q));

    assert_commit_loads_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (live_q == $past(load_val)));

    assert_commit_phase_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase_q == '0));

endmodule

// File: rtl/rtc_mirror_regs.sv
module rtc_mirror_regs
    import rtc_snap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_evt,
    input  rtc_time_t            live,
    input  logic                 host_wr,
    input  logic [OFS_W-1:0]     host_ofs,
    input  logic [7:0]           host_wdata,
    output logic [REG_COUNT-1:0][7:0] reg_view,
    output logic [5:0]           cal_setting,
    output logic                 osc_stop,
    output logic                 load,
    output rtc_time_t            load_val
);
    logic [7:0]  ctrl_q;
    logic        stop_q;
    logic        refresh_pend_q;
    logic [7:0]  fld_q [1:7];
    time_bytes_t live_b;
    time_bytes_t reset_b;
    time_bytes_t fld_b;
    logic        frozen;
    logic        ctrl_wr;

    assign live_b  = to_bytes(live);
    assign reset_b = to_bytes(TIME_AT_RESET);
    assign frozen  = ctrl_q[CTRL_WFRZ] | ctrl_q[CTRL_RFRZ];
    assign ctrl_wr = host_wr && (host_ofs == OFS_CTRL);
    assign load    = ctrl_wr && ctrl_q[CTRL_WFRZ] && !host_wdata[CTRL_WFRZ];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q         <= '0;
            stop_q         <= 1'b1;
            refresh_pend_q <= 1'b0;
        end else begin
            refresh_pend_q <= sec_evt && !frozen;
            if (ctrl_wr) ctrl_q <= host_wdata;
            if (host_wr && host_ofs == OFS_SEC) stop_q <= host_wdata[7];
        end
    end

    for (genvar gi = 1; gi <= 7; gi++) begin : g_fld
        localparam logic [7:0] KEEP = (gi == 1) ? 8'h7F : 8'hFF;
        always_ff @(posedge clk) begin
            if (rst)                                        fld_q[gi] <= reset_b[gi];
            else if (refresh_pend_q)                        fld_q[gi] <= live_b[gi];
            else if (host_wr && host_ofs == OFS_W'(gi))     fld_q[gi] <= host_wdata & KEEP;
        end
        assign fld_b[gi] = fld_q[gi];
        if (gi == 1) begin : g_sec_view
            assign reg_view[gi] = {stop_q, fld_q[gi][6:0]};
        end else begin : g_plain_view
            assign reg_view[gi] = fld_q[gi];
        end
    end

    assign reg_view[0]  = ctrl_q;
    assign cal_setting  = ctrl_q[5:0];
    assign osc_stop     = stop_q;
    assign load_val     = from_bytes(fld_b);

    assert_freeze_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (frozen && !refresh_pend_q && !(host_wr && host_ofs != OFS_CTRL))
        |=> $stable(reg_view[7:1]));

    assert_refresh_completes_R5: assert property (@(posedge clk) disable iff (rst)
        refresh_pend_q |=> ((reg_view[1][6:0] == $past(live.secs)) &&
                            (reg_view[7] == $past(live.year))));

    assert_wfreeze_priority_R11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CTRL_WFRZ] && sec_evt) |=> !refresh_pend_q);

    assert_cal_written_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (cal_setting == $past(host_wdata[5:0])));

endmodule

// File: rtl/rtc_host_ram.sv
module rtc_host_ram #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DEPTH = 248
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        rdata <= mem_q[addr];
    end

endmodule

// File: rtl/rtc_snapshot_ctrl.sv
module rtc_snapshot_ctrl
    import rtc_snap_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned SUBDIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [5:0]        cal_setting,
    output logic              osc_running
);
    localparam int unsigned RAM_DEPTH = (2 ** ADDR_W) - REG_COUNT;

    logic                        in_win;
    logic [OFS_W-1:0]            ofs;
    logic [ADDR_W-1:0]           ram_addr;
    logic                        win_q;
    logic [7:0]                  reg_rd_q;
    logic [7:0]                  ram_rdata;
    logic [REG_COUNT-1:0][7:0]   reg_view;
    logic                        osc_stop;
    logic                        load;
    logic                        sec_evt;
    rtc_time_t                   load_val;
    rtc_time_t                   live;

    assign in_win   = &bus_addr[ADDR_W-1:OFS_W];
    assign ofs      = bus_addr[OFS_W-1:0];
    assign ram_addr = in_win ? '0 : bus_addr;

    rtc_live_counter #(.SUBDIV(SUBDIV)) u_counter (
        .clk(clk), .rst(rst), .phase_tick(phase_tick), .osc_stop(osc_stop),
        .load(load), .load_val(load_val), .live(live), .sec_evt(sec_evt)
    );

    rtc_mirror_regs u_mirror (
        .clk(clk), .rst(rst), .sec_evt(sec_evt), .live(live),
        .host_wr(bus_wr && in_win), .host_ofs(ofs), .host_wdata(bus_wdata),
        .reg_view(reg_view), .cal_setting(cal_setting), .osc_stop(osc_stop),
        .load(load), .load_val(load_val)
    );

    rtc_host_ram #(.AW(ADDR_W), .DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(bus_wr && !in_win), .addr(ram_addr),
        .wdata(bus_wdata), .rdata(ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= 1'b0;
            reg_rd_q <= '0;
        end else begin
            win_q    <= in_win;
            reg_rd_q <= reg_view[ofs];
        end
    end

    assign bus_rdata   = win_q ? reg_rd_q : ram_rdata;
    assign osc_running = !osc_stop;

    assert_window_read_R1: assert property (@(posedge clk) disable iff (rst)
        (in_win && !bus_wr) |=> (bus_rdata == $past(reg_view[ofs])));

endmodule

// File: tb/rtc_snapshot_ctrl_bench.sv
module rtc_snapshot_ctrl_bench;
    localparam int AW     = 8;
    localparam int SUBDIV = 4;
    localparam int BASE   = (2 ** AW) - 8;
    localparam int RAMN   = BASE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phase_tick = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [5:0]    cal_setting;
    logic          osc_running;

    int total = 0;
    int fails = 0;

    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_yr;

    always #4 clk = ~clk;

    rtc_snapshot_ctrl #(.ADDR_W(AW), .SUBDIV(SUBDIV)) u_rtc_snapshot_ctrl (
        .clk(clk), .rst(rst), .phase_tick(phase_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cal_setting(cal_setting), .osc_running(osc_running)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] model_pack();
        return {bcd(m_yr), bcd(m_mon), bcd(m_date), bcd(m_dow), bcd(m_hour), bcd(m_min), bcd(m_sec)};
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > days_in(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic one_tick();
        @(negedge clk); phase_tick = 1'b1;
        @(negedge clk); phase_tick = 1'b0;
    endtask

    task automatic advance(input int secs);
        for (int i = 0; i < secs * SUBDIV; i++) one_tick();
        @(negedge clk);
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        v = '0;
        for (int k = 7; k >= 1; k--) begin
            bus_read(BASE + k, b);
            v = {v[47:0], b};
        end
    endtask

    task automatic set_time();
        bus_write(BASE, 8'h80);
        bus_write(BASE + 1, bcd(m_sec));
        bus_write(BASE + 2, bcd(m_min));
        bus_write(BASE + 3, bcd(m_hour));
        bus_write(BASE + 4, bcd(m_dow));
        bus_write(BASE + 5, bcd(m_date));
        bus_write(BASE + 6, bcd(m_mon));
        bus_write(BASE + 7, bcd(m_yr));
        bus_write(BASE, 8'h00);
    endtask

    task automatic load_model(input int s, input int mi, input int h, input int dw,
                              input int dt, input int mo, input int y);
        m_sec = s; m_min = mi; m_hour = h; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
    endtask

    task automatic rollover_case(input string tag, input int dt, input int mo, input int y);
        logic [55:0] v;
        load_model(59, 59, 23, 3, dt, mo, y);
        set_time();
        advance(1);
        model_tick();
        read_all(v);
        chk(tag, 64'(v), 64'(model_pack()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] v;
        logic [7:0]  ram_ref [RAMN];
        logic        ram_ok  [RAMN];
        void'($urandom(32'd20240229));
        for (int i = 0; i < RAMN; i++) ram_ok[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        bus_read(BASE, b);
        chk("R13 control after reset", 64'(b), 64'h00);
        read_all(v);
        chk("R13 time regs after reset", 64'(v), 64'h00010101000080);
        chk("R9 stopped after reset", 64'(osc_running), 64'h0);
        chk("R10 cal after reset", 64'(cal_setting), 64'h00);

        // R9 stopped oscillator does not count
        advance(2);
        read_all(v);
        chk("R9 no count while stopped", 64'(v), 64'h00010101000080);

        // R9 restart: first second exactly SUBDIV ticks later
        bus_write(BASE + 1, 8'h00);
        chk("R9 running after clear", 64'(osc_running), 64'h1);
        for (int i = 0; i < SUBDIV - 1; i++) one_tick();
        @(negedge clk);
        bus_read(BASE + 1, b);
        chk("R9 not yet one second", 64'(b), 64'h00);
        one_tick(); @(negedge clk);
        bus_read(BASE + 1, b);
        chk("R9 one second after restart", 64'(b), 64'h01);

        // R12 RAM random write/read
        for (int i = 0; i < 16; i++) begin
            int a;
            logic [7:0] d;
            a = $urandom_range(0, RAMN - 1);
            d = 8'($urandom);
            bus_write(a, d);
            ram_ref[a] = d; ram_ok[a] = 1'b1;
        end
        for (int a = 0; a < RAMN; a++) begin
            if (ram_ok[a]) begin
                bus_read(a, b);
                chk("R12 ram readback", 64'(b), 64'(ram_ref[a]));
            end
        end

        // R1 top of RAM vs first/last register
        bus_write(BASE - 1, 8'hA5);
        bus_read(BASE - 1, b);
        chk("R1 last ram byte", 64'(b), 64'hA5);
        bus_read(BASE + 7, b);
        chk("R1 year reg untouched by ram write", 64'(b), 64'h00);

        // R10 calibration field
        bus_write(BASE, 8'h25);
        bus_read(BASE, b);
        chk("R10 cal readback", 64'(b), 64'h25);
        chk("R10 cal output", 64'(cal_setting), 64'h25);
        bus_write(BASE, 8'h00);

        // R8 commit with phase restart (phase left at 2 before commit)
        one_tick(); one_tick();
        load_model(59, 59, 23, 7, 31, 12, 23);
        set_time();
        for (int i = 0; i < SUBDIV - 1; i++) one_tick();
        @(negedge clk);
        bus_read(BASE + 1, b);
        chk("R8 phase restarted at commit", 64'(b), 64'h59);
        one_tick(); @(negedge clk);
        model_tick();
        read_all(v);
        chk("R2 R3 year rollover all fields", 64'(v), 64'(model_pack()));

        // R2 month length and leap cases
        rollover_case("R2 leap feb28", 28, 2, 24);
        rollover_case("R2 leap feb29", 29, 2, 24);
        rollover_case("R2 plain feb28", 28, 2, 23);
        rollover_case("R2 apr30", 30, 4, 10);
        rollover_case("R2 year 99 wrap", 31, 12, 99);

        // R2 R3 random near-rollover trials
        for (int t = 0; t < 12; t++) begin
            int n;
            m_mon  = $urandom_range(1, 12);
            m_yr   = $urandom_range(0, 99);
            m_date = days_in(m_mon, m_yr) - $urandom_range(0, 1);
            m_hour = 23 - $urandom_range(0, 1);
            m_min  = 59;
            m_sec  = 57 + $urandom_range(0, 2);
            m_dow  = $urandom_range(1, 7);
            n      = $urandom_range(1, 3);
            set_time();
            advance(n);
            for (int k = 0; k < n; k++) model_tick();
            read_all(v);
            chk("R2 R3 random advance", 64'(v), 64'(model_pack()));
        end

        // R4 read freeze holds, R6 resume
        load_model(0, 0, 10, 2, 15, 6, 30);
        set_time();
        bus_write(BASE, 8'h40);
        advance(3);
        bus_read(BASE + 1, b);
        chk("R4 frozen seconds", 64'(b), 64'h00);
        bus_write(BASE, 8'h00);
        bus_read(BASE + 1, b);
        chk("R6 no refresh before next second", 64'(b), 64'h00);
        advance(1);
        bus_read(BASE + 1, b);
        chk("R6 refresh after release", 64'(b), 64'h04);

        // R11 write freeze dominates
        bus_write(BASE, 8'hC0);
        advance(2);
        bus_write(BASE, 8'h80);
        advance(2);
        bus_read(BASE + 1, b);
        chk("R11 still frozen after read bit clear", 64'(b), 64'h04);
        bus_write(BASE, 8'h00);
        advance(1);
        bus_read(BASE + 1, b);
        chk("R8 commit of frozen value", 64'(b), 64'h05);

        // R5 freeze write lands in the copy cycle
        for (int i = 0; i < SUBDIV - 1; i++) one_tick();
        @(negedge clk); phase_tick = 1'b1;
        @(negedge clk); phase_tick = 1'b0;
        bus_addr = AW'(BASE); bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        bus_read(BASE + 1, b);
        chk("R5 refresh completes despite freeze", 64'(b), 64'h06);
        advance(1);
        bus_read(BASE + 1, b);
        chk("R4 frozen after collision", 64'(b), 64'h06);
        bus_write(BASE, 8'h00);
        advance(1);
        bus_read(BASE + 1, b);
        chk("R6 resume after collision", 64'(b), 64'h08);

        // R7 host writes persist under write freeze
        bus_write(BASE, 8'h80);
        bus_write(BASE + 2, 8'h33);
        advance(2);
        bus_read(BASE + 2, b);
        chk("R7 written minutes persist", 64'(b), 64'h33);
        bus_write(BASE, 8'h00);
        advance(1);
        bus_read(BASE + 2, b);
        chk("R8 committed minutes", 64'(b), 64'h33);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule